// File: doc/BRIEF.md
# I/O-Port Memory Bank Controller

This block sits between a 16-bit CPU address bus and the memories of a small system. For each memory request it asserts exactly one of four chip selects: boot ROM, main DRAM, video RAM or the memory-mapped peripheral registers. A decoded address can also assert no select at all. The memory map can be changed at run time. An I/O write to one of seven consecutive port numbers either swaps DRAM in for the ROM at the bottom of the map, or swaps DRAM in for the video and I/O window at the top.

Two of the ports do not swap banks. One of them locks the map into a prohibited state, in which the top window answers nothing. The other lifts the lock. Bank writes made while the lock is active are held as pending settings and do not reach the map. Lifting the lock applies the latest pending settings. The selects are combinational from the address and strobes. The bank state is registered, so a port write changes the map starting with the cycle after the clock edge that samples it.

Top module: `bank_ctrl`

## Requirements
- R1: After reset, addresses 0x0000–0x0FFF select ROM, 0xD000–0xDFFF select video RAM, 0xE000–0xE008 select peripherals, and 0xE009–0xFFFF select nothing.
- R2: An I/O write to port 0xE0 makes 0x0000–0x0FFF select DRAM.
- R3: An I/O write to port 0xE1 makes 0xD000–0xFFFF select DRAM.
- R4: An I/O write to port 0xE2 makes 0x0000–0x0FFF select ROM again.
- R5: An I/O write to port 0xE3 restores video RAM at 0xD000–0xDFFF and the peripherals at 0xE000–0xE008.
- R6: An I/O write to port 0xE4 restores ROM at the bottom and the video/peripheral window at the top in one step.
- R7: An I/O write to port 0xE5 enters a locked state. While it lasts, 0xD000–0xFFFF asserts no select, and the lower 4 KiB stays as it was at the moment of locking.
- R8: Writes to 0xE0–0xE4 made while locked update pending settings only. An I/O write to port 0xE6 leaves the locked state and applies the latest pending settings. Outside the locked state, 0xE6 changes nothing.
- R9: The peripheral select is asserted only for 0xE000–0xE008, and only while the top window is open (not swapped to DRAM, not locked).
- R10: Addresses 0x1000–0xCFFF always select DRAM.
- R11: No select is asserted without a memory request. The port number is taken from address bits 7:0 and only when the I/O request and write strobes are both high. Other port numbers (for example 0xE7) and memory writes to addresses with those low bytes leave the map unchanged.
- R12: At most one select is asserted in any cycle.
- R13: A port write changes the map from the cycle after the rising clock edge that samples it. A memory access in the same cycle as the port write still decodes with the old map.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | CPU address; bits 7:0 carry the port number on I/O cycles |
| mreq | input | 1 | Memory request, active high |
| iorq | input | 1 | I/O request, active high |
| wr | input | 1 | Write strobe, active high |
| rom_sel | output | 1 | Boot ROM chip select |
| dram_sel | output | 1 | Main DRAM chip select |
| vram_sel | output | 1 | Video RAM chip select |
| periph_sel | output | 1 | Peripheral register select |

## Verification
A port write and a memory decode can fall in the same cycle. The port write updates registered bank state, and the decode reads that state combinationally. The bench raises the I/O write strobes for port 0xE0 and a memory request on the same address in one cycle. It judges that the select in that cycle is still the ROM and that it becomes the DRAM only after the edge. The lock creates a second overlap: bank writes arrive while the upper window is blanked. The bench checks that the lower 4 KiB does not move until 0xE6, and that 0xE6 then applies the last pending write.

// File: rtl/bank_pkg.sv
package bank_pkg;

   // Chip-select bundle driven by the decoder.
   typedef struct packed {
      logic rom;
      logic dram;
      logic vram;
      logic periph;
   } sel_t;

   // Port offsets from the port base; the order is the behaviour.
   localparam int NUM_PORTS   = 7;
   localparam int OFS_LOW_RAM = 0;
   localparam int OFS_HI_RAM  = 1;
   localparam int OFS_LOW_ROM = 2;
   localparam int OFS_HI_IO   = 3;
   localparam int OFS_ALL_STD = 4;
   localparam int OFS_LOCK    = 5;
   localparam int OFS_UNLOCK  = 6;

endpackage

// File: rtl/bank_flags.sv
module bank_flags
   import bank_pkg::*;
#(
   parameter int PORT_W    = 8,
   parameter int PORT_BASE = 'hE0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              io_wr,
   input  logic [PORT_W-1:0] port,
   output logic              low_dram,
   output logic              high_dram,
   output logic              locked
);

   logic [NUM_PORTS-1:0] hit;
   logic pend_low, pend_high, frz_low, lock_q;

   generate
      if (PORT_BASE + NUM_PORTS > (1 << PORT_W)) begin : g_bad_ports
         $error("bank_flags: port block does not fit PORT_W");
      end
      for (genvar gi = 0; gi < NUM_PORTS; gi++) begin : g_hit
         assign hit[gi] = io_wr && (port == PORT_W'(PORT_BASE + gi));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_low  <= 1'b0;
         pend_high <= 1'b0;
         frz_low   <= 1'b0;
         lock_q    <= 1'b0;
      end else begin
         if (hit[OFS_LOW_RAM]) pend_low <= 1'b1;
         if (hit[OFS_LOW_ROM] || hit[OFS_ALL_STD]) pend_low <= 1'b0;
         if (hit[OFS_HI_RAM]) pend_high <= 1'b1;
         if (hit[OFS_HI_IO] || hit[OFS_ALL_STD]) pend_high <= 1'b0;
         if (hit[OFS_LOCK] && !lock_q) begin
            lock_q  <= 1'b1;
            frz_low <= pend_low;
         end
         if (hit[OFS_UNLOCK]) lock_q <= 1'b0;
      end
   end

   assign low_dram  = lock_q ? frz_low : pend_low;
   assign high_dram = pend_high;
   assign locked    = lock_q;

   assert_low_ram_R2: assert property (@(posedge clk) disable iff (!rst_n)
      hit[OFS_LOW_RAM] && !locked |=> low_dram);
   assert_low_rom_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (hit[OFS_LOW_ROM] || hit[OFS_ALL_STD]) && !locked |=> !low_dram);
   assert_hi_ram_R3: assert property (@(posedge clk) disable iff (!rst_n)
      hit[OFS_HI_RAM] |=> high_dram);
   assert_hi_std_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (hit[OFS_HI_IO] || hit[OFS_ALL_STD]) |=> !high_dram);
   assert_lock_enter_R7: assert property (@(posedge clk) disable iff (!rst_n)
      hit[OFS_LOCK] |=> locked);
   assert_lock_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      locked && !hit[OFS_UNLOCK] |=> locked && $stable(low_dram));
   assert_unlock_R8: assert property (@(posedge clk) disable iff (!rst_n)
      hit[OFS_UNLOCK] |=> !locked);
   assert_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
      !io_wr |=> $stable(low_dram) && $stable(high_dram) && $stable(locked));

endmodule

// File: rtl/bank_decode.sv
module bank_decode
   import bank_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int ROM_LAST   = 'h0FFF,
   parameter int VRAM_BASE  = 'hD000,
   parameter int IO_BASE    = 'hE000,
   parameter int PERIPH_CNT = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              mreq,
   input  logic              low_dram,
   input  logic              high_dram,
   input  logic              locked,
   output sel_t              sel
);

   localparam int PERIPH_LAST = IO_BASE + PERIPH_CNT - 1;

   generate
      if (!(ROM_LAST < VRAM_BASE && VRAM_BASE < IO_BASE)) begin : g_bad_order
         $error("bank_decode: regions out of order");
      end
      if (PERIPH_CNT < 1 || PERIPH_LAST >= (1 << ADDR_W)) begin : g_bad_periph
         $error("bank_decode: peripheral window does not fit");
      end
   endgenerate

   logic in_low, in_upper, in_vram, in_periph, upper_open;

   always_comb begin
      in_low     = addr <= ADDR_W'(ROM_LAST);
      in_upper   = addr >= ADDR_W'(VRAM_BASE);
      in_vram    = in_upper && (addr < ADDR_W'(IO_BASE));
      in_periph  = (addr >= ADDR_W'(IO_BASE)) && (addr <= ADDR_W'(PERIPH_LAST));
      upper_open = !locked && !high_dram;

      sel.rom    = mreq && in_low && !low_dram;
      sel.vram   = mreq && in_vram && upper_open;
      sel.periph = mreq && in_periph && upper_open;
      sel.dram   = mreq && ((in_low && low_dram) ||
                            (!in_low && !in_upper) ||
                            (in_upper && high_dram && !locked));
   end

   assert_sel_onehot_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel));
   assert_no_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !mreq |-> (sel == '0));
   assert_periph_span_R9: assert property (@(posedge clk) disable iff (!rst_n)
      sel.periph |-> (addr >= ADDR_W'(IO_BASE)) && (addr <= ADDR_W'(PERIPH_LAST)) && !locked);
   assert_lock_blank_R7: assert property (@(posedge clk) disable iff (!rst_n)
      mreq && locked && (addr >= ADDR_W'(VRAM_BASE)) |-> (sel == '0));
   assert_mid_dram_R10: assert property (@(posedge clk) disable iff (!rst_n)
      mreq && (addr > ADDR_W'(ROM_LAST)) && (addr < ADDR_W'(VRAM_BASE)) |-> sel.dram);

endmodule

// File: rtl/bank_ctrl.sv
module bank_ctrl
   import bank_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int PORT_W     = 8,
   parameter int PORT_BASE  = 'hE0,
   parameter int ROM_LAST   = 'h0FFF,
   parameter int VRAM_BASE  = 'hD000,
   parameter int IO_BASE    = 'hE000,
   parameter int PERIPH_CNT = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              mreq,
   input  logic              iorq,
   input  logic              wr,
   output logic              rom_sel,
   output logic              dram_sel,
   output logic              vram_sel,
   output logic              periph_sel
);

   generate
      if (PORT_W > ADDR_W) begin : g_bad_port_w
         $error("bank_ctrl: port field wider than address");
      end
   endgenerate

   logic low_dram, high_dram, locked;
   sel_t sel;

   bank_flags #(.PORT_W(PORT_W), .PORT_BASE(PORT_BASE)) u_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .io_wr     (iorq && wr),
      .port      (addr[PORT_W-1:0]),
      .low_dram  (low_dram),
      .high_dram (high_dram),
      .locked    (locked)
   );

   bank_decode #(
      .ADDR_W(ADDR_W), .ROM_LAST(ROM_LAST), .VRAM_BASE(VRAM_BASE),
      .IO_BASE(IO_BASE), .PERIPH_CNT(PERIPH_CNT)
   ) u_dec (
      .clk       (clk),
      .rst_n     (rst_n),
      .addr      (addr),
      .mreq      (mreq),
      .low_dram  (low_dram),
      .high_dram (high_dram),
      .locked    (locked),
      .sel       (sel)
   );

   assign rom_sel    = sel.rom;
   assign dram_sel   = sel.dram;
   assign vram_sel   = sel.vram;
   assign periph_sel = sel.periph;

endmodule

// File: tb/bank_ctrl_tb.sv
module bank_ctrl_tb;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [15:0] addr = '0;
   logic mreq = 1'b0, iorq = 1'b0, wr = 1'b0;
   logic rom_sel, dram_sel, vram_sel, periph_sel;
   int checks = 0, errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   bank_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .mreq(mreq), .iorq(iorq), .wr(wr),
      .rom_sel(rom_sel), .dram_sel(dram_sel), .vram_sel(vram_sel), .periph_sel(periph_sel)
   );

   // Select codes {rom,dram,vram,periph}
   localparam logic [3:0] S_ROM = 4'b1000, S_RAM = 4'b0100, S_VRM = 4'b0010,
                          S_PER = 4'b0001, S_NON = 4'b0000;

   // {do_io, port, probe addr, expected select}
   localparam int NV = 25;
   localparam logic [28:0] VEC [NV] = '{
      {1'b0, 8'h00, 16'h0000, S_ROM},   // R1
      {1'b0, 8'h00, 16'h1234, S_RAM},   // R10
      {1'b0, 8'h00, 16'hD000, S_VRM},   // R1
      {1'b0, 8'h00, 16'hE008, S_PER},   // R9
      {1'b0, 8'h00, 16'hE009, S_NON},   // R9
      {1'b1, 8'hE0, 16'h0FFF, S_RAM},   // R2
      {1'b0, 8'h00, 16'hD7FF, S_VRM},   // R2 upper untouched
      {1'b1, 8'hE1, 16'hD000, S_RAM},   // R3
      {1'b0, 8'h00, 16'hE004, S_RAM},   // R3/R9
      {1'b1, 8'hE2, 16'h0000, S_ROM},   // R4
      {1'b1, 8'hE3, 16'hE000, S_PER},   // R5
      {1'b1, 8'hE0, 16'h0800, S_RAM},   // R2
      {1'b1, 8'hE1, 16'hFFFF, S_RAM},   // R3
      {1'b1, 8'hE4, 16'h0000, S_ROM},   // R6
      {1'b0, 8'h00, 16'hDFFF, S_VRM},   // R6
      {1'b1, 8'hE5, 16'hD000, S_NON},   // R7
      {1'b0, 8'h00, 16'hE000, S_NON},   // R7
      {1'b0, 8'h00, 16'h0000, S_ROM},   // R7 lower frozen
      {1'b1, 8'hE0, 16'h0000, S_ROM},   // R8 pending only
      {1'b1, 8'hE1, 16'h1000, S_RAM},   // R8/R10
      {1'b1, 8'hE6, 16'h0000, S_RAM},   // R8 applies pending low
      {1'b0, 8'h00, 16'hD000, S_RAM},   // R8 applies pending high
      {1'b1, 8'hE7, 16'h0000, S_RAM},   // R11 other port
      {1'b1, 8'hE4, 16'hE001, S_PER},   // R6
      {1'b1, 8'hE6, 16'h0000, S_ROM}    // R8 unlock when open
   };

   function automatic logic [3:0] cur_sel();
      return {rom_sel, dram_sel, vram_sel, periph_sel};
   endfunction

   task automatic check(input string req, input logic [3:0] exp);
      checks++;
      if (cur_sel() !== exp) begin
         errors++;
         $display("FAIL %s: select actual %b expected %b (addr %h)", req, cur_sel(), exp, addr);
      end
   endtask

   task automatic io_write(input logic [15:0] a);
      @(negedge clk);
      mreq = 1'b0; iorq = 1'b1; wr = 1'b1; addr = a;
      @(negedge clk);
      iorq = 1'b0; wr = 1'b0;
   endtask

   task automatic probe(input logic [15:0] a, input logic [3:0] exp, input string req);
      mreq = 1'b1; addr = a;
      #1 check(req, exp);
      mreq = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      #800000;
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      do_reset();
      // R1: reset map
      probe(16'h0000, S_ROM, "R1");

      for (int i = 0; i < NV; i++) begin
         logic [28:0] v;
         v = VEC[i];
         if (v[28]) io_write({8'h00, v[27:20]});
         else @(negedge clk);
         probe(v[19:4], v[3:0], $sformatf("R1-table vector %0d", i));
      end

      // R11: no memory request, no select
      @(negedge clk);
      mreq = 1'b0; addr = 16'h0000;
      #1 check("R11 idle", S_NON);

      // R11: memory write to low byte 0xE0 does not switch
      @(negedge clk);
      mreq = 1'b1; wr = 1'b1; iorq = 1'b0; addr = 16'h00E0;
      @(negedge clk);
      mreq = 1'b0; wr = 1'b0;
      probe(16'h0000, S_ROM, "R11 mem write");

      // R11: I/O read (no wr) ignored
      @(negedge clk);
      iorq = 1'b1; wr = 1'b0; addr = 16'h00E0;
      @(negedge clk);
      iorq = 1'b0;
      probe(16'h0000, S_ROM, "R11 io read");

      // R11: upper address byte ignored for port number
      io_write(16'h5AE0);
      probe(16'h0000, S_RAM, "R11 upper byte");
      io_write(16'h00E2);
      probe(16'h0000, S_ROM, "R4 restore");

      // R13: same-cycle port write and memory access
      @(negedge clk);
      iorq = 1'b1; wr = 1'b1; mreq = 1'b1; addr = 16'h00E0;
      #1 check("R13 old map", S_ROM);
      @(negedge clk);
      iorq = 1'b0; wr = 1'b0;
      #1 check("R13 new map", S_RAM);
      mreq = 1'b0;

      // R8: lock, change low back during lock, second lock ignored, unlock
      io_write(16'h00E5);
      io_write(16'h00E2);
      probe(16'h0000, S_RAM, "R7 frozen");
      io_write(16'h00E5);
      io_write(16'h00E6);
      probe(16'h0000, S_ROM, "R8 latest");
      probe(16'hD800, S_VRM, "R8 upper back");

      // R1: reset from a switched and locked map
      io_write(16'h00E0);
      io_write(16'h00E1);
      io_write(16'h00E5);
      do_reset();
      probe(16'h0000, S_ROM, "R1 after reset");
      probe(16'hD000, S_VRM, "R1 vram after reset");
      probe(16'hE000, S_PER, "R1 periph after reset");

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule